// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block sits between a framebuffer word fetcher and a palette or display pipe. It takes 32-bit framebuffer words on a valid/ready stream and emits one pixel per handshake on a second valid/ready stream. The pixel depth is chosen by a 3-bit code. Depths of 8 bits or fewer produce a palette index that an external lookup resolves. Wider depths are expanded into a 24-bit colour, with red in bits 23:16, green in 15:8 and blue in 7:0.

Three orderings of pixels inside a word are supported. A red/blue placement bit and a 2-bit reinterpretation input adjust how 16-bit pixels are read. A combinational side output gives the number of source bytes that one display line of a given width occupies, which a fetch engine can use to size its line bursts.

The parameter `EXTENDED` selects the richer variant. In that variant, codes 6 and 7 are native formats and the 2-bit input has no effect.

Top module: `pix_unpack`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pix_valid` is 0 and `word_ready` is 1. A reset drops any word that was partly unpacked.
- R2: `line_bytes` is `cfg_width`>>3, >>2, >>1 or unchanged for depth codes 0, 1, 2 and 3. It is `cfg_width`*2 for codes 4, 6 and 7, and `cfg_width`*4 for code 5.
- R3: With `cfg_be_all`=0 and `cfg_be_pix`=0, pixel k of a word comes from bits [k*C +: C]. C is the container size: 1, 2, 4, 8, 16 or 32 bits for codes 0 to 5, and 16 for codes 6 and 7. A word yields 32/C pixels.
- R4: With `cfg_be_all`=1, pixel k comes from bits [32-(k+1)*C +: C], so pixel 0 sits at the most significant end.
- R5: With `cfg_be_all`=0 and `cfg_be_pix`=1, sub-byte pixels are read from bit 7 downward inside each byte, and bytes are still taken from byte 0 upward. For C of 8 or more the order is as in R3. `cfg_be_all`=1 overrides `cfg_be_pix`.
- R6: Codes 0 to 3 give `pix_is_index`=1, with the zero-extended index in `pix_rgb`[7:0] and 0 in `pix_rgb`[23:8].
- R7: Code 5 takes channel fields from bits 7:0, 15:8 and 23:16 and ignores bits 31:24. With `cfg_bgr`=1, bits 7:0 become red and bits 23:16 become blue. With `cfg_bgr`=0 these two are swapped. Green is always bits 15:8.
- R8: The 5:5:5:1 format takes fields from bits 4:0, 9:5 and 14:10, shifts each left by 3, and ignores bit 15. Red and blue are placed as in R7.
- R9: On the extended variant, code 6 is 5:6:5. It takes bits 4:0 (shift 3), bits 10:5 as green (shift 2) and bits 15:11 (shift 3). Red and blue are placed as in R7.
- R10: On the extended variant, code 7 is 4:4:4. It takes nibbles 3:0, 7:4 and 11:8, each shifted left by 4, and ignores bits 15:12. Red and blue are placed as in R7.
- R11: On the base variant, codes 4, 6 and 7 are all read through `fmt_mux`. Value 1 selects 5:5:5:1. Value 3 selects 5:6:5 placed as if `cfg_bgr`=1. Values 0 and 2 select 5:6:5 and honour `cfg_bgr`.
- R12: On the extended variant, code 4 is always 5:5:5:1, whatever the value of `fmt_mux`.
- R13: The first pixel of an accepted word is valid in the next cycle. While `pix_valid`=1 and `pix_ready`=0, the pixel holds steady and `word_ready` is 0. Pixels leave in order, with none dropped or repeated, and a new word can be accepted in the same cycle as the previous word's last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | 3 | Depth code 0 to 7 |
| cfg_bgr | input | 1 | Red/blue placement select |
| cfg_be_all | input | 1 | Big-endian bytes and pixels |
| cfg_be_pix | input | 1 | Big-endian pixels inside little-endian bytes |
| fmt_mux | input | 2 | 16-bit reinterpretation select (base variant) |
| cfg_width | input | WIDTH_W | Line width in pixels |
| line_bytes | output | WIDTH_W+2 | Source bytes per line |
| word_valid | input | 1 | Framebuffer word offered |
| word_ready | output | 1 | Framebuffer word accepted |
| word_data | input | 32 | Framebuffer word |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Pixel taken downstream |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_rgb | output | 24 | Colour, or index in bits 7:0 |

## Verification
The assertions take the configuration inputs to be steady whenever an unpacked word is in flight. Under that assumption, a held pixel, and the index flag that follows the depth code, are functions of state alone.

The stimulus changes the configuration only at falling edges, and only after the previous word has fully drained, when `pix_valid` is low. The one test with backpressure keeps the whole configuration fixed from the first word to the last pixel.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    FMT_I1   = 3'd0,
    FMT_I2   = 3'd1,
    FMT_I4   = 3'd2,
    FMT_I8   = 3'd3,
    FMT_5551 = 3'd4,
    FMT_888  = 3'd5,
    FMT_565  = 3'd6,
    FMT_444  = 3'd7
  } fmt_e;

  typedef enum logic [1:0] {
    ORD_LL = 2'd0,
    ORD_BB = 2'd1,
    ORD_LB = 2'd2
  } order_e;

  typedef struct packed {
    logic        is_index;
    logic [23:0] rgb;
  } pixel_t;

  // log2 of the container size in bits
  function automatic logic [2:0] container_log2(fmt_e f);
    case (f)
      FMT_I1:  return 3'd0;
      FMT_I2:  return 3'd1;
      FMT_I4:  return 3'd2;
      FMT_I8:  return 3'd3;
      FMT_888: return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] field_mask(logic [2:0] l2c);
    case (l2c)
      3'd0:    return 32'h0000_0001;
      3'd1:    return 32'h0000_0003;
      3'd2:    return 32'h0000_000F;
      3'd3:    return 32'h0000_00FF;
      3'd4:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // big-endian-all wins over big-endian-pixel
  function automatic order_e pick_order(logic be_all, logic be_pix);
    if (be_all)      return ORD_BB;
    else if (be_pix) return ORD_LB;
    else             return ORD_LL;
  endfunction

  // Rearranges a word so that pixel k always sits at bits [k*C +: C].
  function automatic logic [WORD_W-1:0] reorder(logic [WORD_W-1:0] w,
                                                logic [2:0] l2c,
                                                order_e ord);
    logic [WORD_W-1:0] r;
    int c, g, off, src;
    c = 1 << l2c;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      g   = i >> l2c;
      off = i & (c - 1);
      case (ord)
        ORD_BB: src = WORD_W - c * (g + 1) + off;
        ORD_LB: begin
          if (l2c < 3'd3) src = (i & ~7) + (8 - c * (((i & 7) >> l2c) + 1)) + off;
          else            src = i;
        end
        default: src = i;
      endcase
      r[i] = w[src[4:0]];
    end
    return r;
  endfunction

  function automatic logic [31:0] bytes_for(logic [2:0] code, logic [31:0] w);
    case (code)
      3'd0:    return w >> 3;
      3'd1:    return w >> 2;
      3'd2:    return w >> 1;
      3'd3:    return w;
      3'd5:    return w << 2;
      default: return w << 1;
    endcase
  endfunction

  function automatic logic [7:0] widen4(logic [3:0] v);
    return {v, 4'b0000};
  endfunction

  function automatic logic [7:0] widen5(logic [4:0] v);
    return {v, 3'b000};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] v);
    return {v, 2'b00};
  endfunction

  // raw holds the pixel field right-aligned, upper bits zero
  function automatic pixel_t decode(fmt_e f, logic bgr, logic [WORD_W-1:0] raw);
    pixel_t     p;
    logic [7:0] lo, mid, hi;
    p   = '0;
    lo  = '0;
    mid = '0;
    hi  = '0;
    case (f)
      FMT_5551: begin
        lo  = widen5(raw[4:0]);
        mid = widen5(raw[9:5]);
        hi  = widen5(raw[14:10]);
      end
      FMT_565: begin
        lo  = widen5(raw[4:0]);
        mid = widen6(raw[10:5]);
        hi  = widen5(raw[15:11]);
      end
      FMT_444: begin
        lo  = widen4(raw[3:0]);
        mid = widen4(raw[7:4]);
        hi  = widen4(raw[11:8]);
      end
      FMT_888: begin
        lo  = raw[7:0];
        mid = raw[15:8];
        hi  = raw[23:16];
      end
      default: begin
        p.is_index = 1'b1;
        p.rgb      = {16'h0000, raw[7:0]};
      end
    endcase
    if (!p.is_index) p.rgb = bgr ? {lo, mid, hi} : {hi, mid, lo};
    return p;
  endfunction

endpackage

// File: rtl/pix_unpack_fmtsel.sv
module pix_unpack_fmtsel
  import pix_unpack_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic [2:0] depth,
  input  logic       bgr_in,
  input  logic [1:0] mux,
  output fmt_e       fmt,
  output logic       bgr_out,
  output logic [2:0] l2c
);

  generate
    if (EXTENDED) begin : g_ext
      always_comb begin
        fmt     = fmt_e'(depth);
        bgr_out = bgr_in;
      end
    end else begin : g_base
      logic is_sixteen;
      assign is_sixteen = depth[2] && (depth != 3'd5);
      always_comb begin
        bgr_out = bgr_in;
        fmt     = fmt_e'(depth);
        if (is_sixteen) begin
          case (mux)
            2'd1:    fmt = FMT_5551;
            2'd3: begin
              fmt     = FMT_565;
              bgr_out = 1'b1;
            end
            default: fmt = FMT_565;
          endcase
        end
      end
    end
  endgenerate

  assign l2c = container_log2(fmt);

endmodule

// File: rtl/pix_unpack_order.sv
module pix_unpack_order
  import pix_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic [2:0]        l2c,
  input  logic              be_all,
  input  logic              be_pix,
  output logic [WORD_W-1:0] word_out
);

  order_e ord;

  assign ord      = pick_order(be_all, be_pix);
  assign word_out = reorder(word_in, l2c, ord);

endmodule

// File: rtl/pix_unpack_slicer.sv
module pix_unpack_slicer
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        l2c,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              slot_valid,
  input  logic              slot_ready,
  output logic [WORD_W-1:0] slot_field,
  output logic              word_take,
  output logic              slot_take
);

  logic [WORD_W-1:0] hold;
  logic              hold_valid;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  shamt;
  logic              at_last;

  assign last_idx   = IDX_W'((WORD_W >> l2c) - 1);
  assign at_last    = (idx == last_idx);
  assign slot_valid = hold_valid;
  assign slot_take  = hold_valid && slot_ready;
  assign word_ready = !hold_valid || (slot_take && at_last);
  assign word_take  = word_valid && word_ready;
  assign shamt      = idx << l2c;
  assign slot_field = (hold >> shamt) & field_mask(l2c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold       <= '0;
      hold_valid <= 1'b0;
      idx        <= '0;
    end else if (word_take) begin
      hold       <= word_data;
      hold_valid <= 1'b1;
      idx        <= '0;
    end else if (slot_take) begin
      if (at_last) hold_valid <= 1'b0;
      else         idx        <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int WIDTH_W  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cfg_depth,
  input  logic                 cfg_bgr,
  input  logic                 cfg_be_all,
  input  logic                 cfg_be_pix,
  input  logic [1:0]           fmt_mux,
  input  logic [WIDTH_W-1:0]   cfg_width,
  output logic [WIDTH_W+1:0]   line_bytes,
  input  logic                 word_valid,
  output logic                 word_ready,
  input  logic [31:0]          word_data,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic                 pix_is_index,
  output logic [23:0]          pix_rgb
);

  localparam int LB_W = WIDTH_W + 2;

  fmt_e              fmt;
  logic              eff_bgr;
  logic [2:0]        l2c;
  logic [WORD_W-1:0] ordered;
  logic [WORD_W-1:0] field;
  logic              word_take;
  logic              pix_take;
  pixel_t            pix;

  pix_unpack_fmtsel #(.EXTENDED(EXTENDED)) u_fmtsel (
    .depth   (cfg_depth),
    .bgr_in  (cfg_bgr),
    .mux     (fmt_mux),
    .fmt     (fmt),
    .bgr_out (eff_bgr),
    .l2c     (l2c)
  );

  pix_unpack_order u_order (
    .word_in  (word_data),
    .l2c      (l2c),
    .be_all   (cfg_be_all),
    .be_pix   (cfg_be_pix),
    .word_out (ordered)
  );

  pix_unpack_slicer u_slicer (
    .clk        (clk),
    .rst_n      (rst_n),
    .l2c        (l2c),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (ordered),
    .slot_valid (pix_valid),
    .slot_ready (pix_ready),
    .slot_field (field),
    .word_take  (word_take),
    .slot_take  (pix_take)
  );

  assign pix          = decode(fmt, eff_bgr, field);
  assign pix_is_index = pix.is_index;
  assign pix_rgb      = pix.rgb;
  assign line_bytes   = LB_W'(bytes_for(cfg_depth, 32'(cfg_width)));

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
  parameter bit EXTENDED = 1'b0,
  parameter int WIDTH_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         cfg_depth,
  input logic [WIDTH_W+1:0] line_bytes,
  input logic               word_ready,
  input logic               pix_valid,
  input logic               pix_ready,
  input logic               pix_is_index,
  input logic [23:0]        pix_rgb,
  input logic               word_take,
  input logic               pix_take
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_rgb) && $stable(pix_is_index)); // R13

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |-> !word_ready); // R13

  AST_FIRST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |=> pix_valid); // R13

  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take |-> pix_valid && pix_ready); // R13

  AST_INDEX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && (cfg_depth <= 3'd3) |-> pix_is_index && (pix_rgb[23:8] == 16'h0)); // R6

  AST_COLOUR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && cfg_depth[2] |-> !pix_is_index); // R7

  AST_NIBBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && EXTENDED && (cfg_depth == 3'd7)
      |-> (pix_rgb[3:0] == 4'h0) && (pix_rgb[11:8] == 4'h0) && (pix_rgb[19:16] == 4'h0)); // R10

  AST_WORD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_depth == 3'd5) |-> (line_bytes[1:0] == 2'b00)); // R2

endmodule

bind pix_unpack pix_unpack_chk #(.EXTENDED(EXTENDED), .WIDTH_W(WIDTH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_depth    (cfg_depth),
  .line_bytes   (line_bytes),
  .word_ready   (word_ready),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_is_index (pix_is_index),
  .pix_rgb      (pix_rgb),
  .word_take    (word_take),
  .pix_take     (pix_take)
);

// File: tb/pix_unpack_bench.sv
module pix_unpack_bench;

  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg_depth = '0;
  logic          cfg_bgr = 1'b0;
  logic          cfg_be_all = 1'b0;
  logic          cfg_be_pix = 1'b0;
  logic [1:0]    fmt_mux = 2'd1;
  logic [WW-1:0] cfg_width = '0;
  logic [WW+1:0] line_bytes, x_line_bytes;
  logic          word_valid = 1'b0;
  logic          word_ready, x_word_ready;
  logic [31:0]   word_data = '0;
  logic          pix_valid, x_pix_valid;
  logic          pix_ready = 1'b0;
  logic          pix_is_index, x_pix_is_index;
  logic [23:0]   pix_rgb, x_pix_rgb;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  pix_unpack #(.EXTENDED(1'b0), .WIDTH_W(WW)) u_pix_unpack (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_all(cfg_be_all), .cfg_be_pix(cfg_be_pix), .fmt_mux(fmt_mux),
    .cfg_width(cfg_width), .line_bytes(line_bytes), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_is_index(pix_is_index), .pix_rgb(pix_rgb)
  );

  pix_unpack #(.EXTENDED(1'b1), .WIDTH_W(WW)) u_pix_unpack_x (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_bgr(cfg_bgr),
    .cfg_be_all(cfg_be_all), .cfg_be_pix(cfg_be_pix), .fmt_mux(fmt_mux),
    .cfg_width(cfg_width), .line_bytes(x_line_bytes), .word_valid(word_valid),
    .word_ready(x_word_ready), .word_data(word_data), .pix_valid(x_pix_valid),
    .pix_ready(pix_ready), .pix_is_index(x_pix_is_index), .pix_rgb(x_pix_rgb)
  );

  typedef struct packed {
    logic        ext;
    logic [2:0]  depth;
    logic        bgr;
    logic        be_all;
    logic        be_pix;
    logic [1:0]  mux;
    logic [31:0] word;
    logic [4:0]  k;
    logic [5:0]  npix;
    logic        is_idx;
    logic [23:0] rgb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam logic [31:0] W = 32'h8C3A_5E71;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd32, 1'b1, 24'h000001, 4'd3},  // R3
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd7, 6'd32, 1'b1, 24'h000000, 4'd3},  // R3
    '{1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1, W, 5'd0, 6'd32, 1'b1, 24'h000001, 4'd4},  // R4
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 2'd1, W, 5'd1, 6'd32, 1'b1, 24'h000001, 4'd5},  // R5
    '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd3, 6'd16, 1'b1, 24'h000001, 4'd3},  // R3
    '{1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 2'd1, W, 5'd0, 6'd16, 1'b1, 24'h000002, 4'd4},  // R4
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd2, 6'd8,  1'b1, 24'h00000E, 4'd3},  // R3
    '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 2'd1, W, 5'd1, 6'd8,  1'b1, 24'h00000C, 4'd4},  // R4
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd1, W, 5'd0, 6'd8,  1'b1, 24'h000007, 4'd5},  // R5
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd1, W, 5'd3, 6'd8,  1'b1, 24'h00000E, 4'd5},  // R5
    '{1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd1, 6'd4,  1'b1, 24'h00005E, 4'd6},  // R6
    '{1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 2'd1, W, 5'd1, 6'd4,  1'b1, 24'h00005E, 4'd5},  // R5
    '{1'b0, 3'd3, 1'b0, 1'b1, 1'b0, 2'd1, W, 5'd0, 6'd4,  1'b1, 24'h00008C, 4'd4},  // R4
    '{1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 2'd1, W, 5'd0, 6'd4,  1'b1, 24'h00008C, 4'd5},  // R5
    '{1'b0, 3'd5, 1'b1, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd1,  1'b0, 24'h715E3A, 4'd7},  // R7
    '{1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd1,  1'b0, 24'h3A5E71, 4'd7},  // R7
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'h8898B8, 4'd8},  // R8
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd1, 6'd2,  1'b0, 24'h1808D0, 4'd8},  // R8
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd0, W, 5'd0, 6'd2,  1'b0, 24'h88CC58, 4'd11}, // R11
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd2, W, 5'd0, 6'd2,  1'b0, 24'h58CC88, 4'd11}, // R11
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, W, 5'd0, 6'd2,  1'b0, 24'h88CC58, 4'd11}, // R11
    '{1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'h8898B8, 4'd11}, // R11
    '{1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 2'd0, W, 5'd0, 6'd2,  1'b0, 24'h8898B8, 4'd12}, // R12
    '{1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'h88CC58, 4'd9},  // R9
    '{1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'h58CC88, 4'd9},  // R9
    '{1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 2'd1, W, 5'd1, 6'd2,  1'b0, 24'hA030C0, 4'd10}, // R10
    '{1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'hD00818, 4'd4},  // R4
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 2'd1, W, 5'd0, 6'd2,  1'b0, 24'h8898B8, 4'd5}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  function automatic int exp_bytes(int code, int w);
    case (code)
      0: return w / 8;
      1: return w / 4;
      2: return w / 2;
      3: return w;
      5: return w * 4;
      default: return w * 2;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog R13 actual=timeout expected=completion");
    summary();
  end

  initial begin
    vec_t        v;
    int          cnt;
    logic [24:0] got;
    logic [7:0]  seq [8];
    int          nseq;
    bit          taken;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pix_valid == 1'b0, "R1", 32'(pix_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0 && word_ready == 1'b1, "R1",
        {30'h0, pix_valid, word_ready}, 32'h1);

    // R2: bytes per line
    for (int code = 0; code < 8; code++) begin
      cfg_depth = 3'(code);
      cfg_width = 12'd640;
      #1;
      chk(int'(line_bytes) == exp_bytes(code, 640), "R2",
          32'(line_bytes), 32'(exp_bytes(code, 640)));
      cfg_width = 12'd13;
      #1;
      chk(int'(line_bytes) == exp_bytes(code, 13), "R2",
          32'(line_bytes), 32'(exp_bytes(code, 13)));
    end

    // Table walk: decode and ordering on both variants
    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      @(negedge clk);
      cfg_depth  = v.depth;
      cfg_bgr    = v.bgr;
      cfg_be_all = v.be_all;
      cfg_be_pix = v.be_pix;
      fmt_mux    = v.mux;
      word_data  = v.word;
      word_valid = 1'b1;
      pix_ready  = 1'b1;
      #1;
      while (!word_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      word_valid = 1'b0;
      cnt = 0;
      got = '1;
      while ((v.ext ? x_pix_valid : pix_valid) && cnt < 40) begin
        if (cnt == int'(v.k))
          got = v.ext ? {x_pix_is_index, x_pix_rgb} : {pix_is_index, pix_rgb};
        cnt++;
        @(negedge clk);
      end
      chk(got == {v.is_idx, v.rgb}, $sformatf("R%0d vec%0d", v.req, n),
          32'(got), 32'({v.is_idx, v.rgb}));
      chk(cnt == int'(v.npix), $sformatf("R3 count vec%0d", n),
          32'(cnt), 32'(v.npix));
    end

    // R13: backpressure, then alternating ready with a second word queued
    @(negedge clk);
    cfg_depth  = 3'd3;
    cfg_bgr    = 1'b0;
    cfg_be_all = 1'b0;
    cfg_be_pix = 1'b0;
    fmt_mux    = 2'd1;
    pix_ready  = 1'b0;
    word_data  = 32'h4433_2211;
    word_valid = 1'b1;
    @(negedge clk);
    word_data = 32'h8877_6655;
    for (int i = 0; i < 3; i++) begin
      chk(pix_valid && pix_rgb == 24'h11, "R13 hold", {7'h0, pix_valid, pix_rgb},
          32'h0100_0011);
      chk(word_ready == 1'b0, "R13 stall", 32'(word_ready), 32'h0);
      @(negedge clk);
    end
    nseq  = 0;
    taken = 1'b0;
    for (int c = 0; c < 40 && nseq < 8; c++) begin
      if (taken) word_valid = 1'b0;
      pix_ready = c[0];
      #1;
      if (word_valid && word_ready) taken = 1'b1;
      if (pix_valid && pix_ready) begin
        seq[nseq] = pix_rgb[7:0];
        nseq++;
      end
      @(negedge clk);
    end
    word_valid = 1'b0;
    pix_ready  = 1'b1;
    chk(nseq == 8, "R13 count", 32'(nseq), 32'd8);
    for (int i = 0; i < 8; i++)
      chk(seq[i] == 8'(8'h11 * (i + 1)), "R13 order", 32'(seq[i]), 32'(8'h11 * (i + 1)));
    @(negedge clk);
    chk(pix_valid == 1'b0, "R13 drained", 32'(pix_valid), 32'h0);

    // R1: reset drops a partly unpacked word
    pix_ready  = 1'b0;
    word_data  = 32'hDEAD_BEEF;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    chk(pix_valid == 1'b1, "R1 preload", 32'(pix_valid), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1 in reset", 32'(pix_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b0 && word_ready == 1'b1, "R1 after reset",
        {30'h0, pix_valid, word_ready}, 32'h1);

    summary();
  end

endmodule